// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block is a 16-bit up-counter that advances on ticks taken either from a power-of-two prescaler running on the bus clock, or from an external accumulator clock. The external clock can be used directly, divided by 256 or divided by 65536. When the counter wraps from all ones to zero it raises an overflow flag, and the flag can drive an interrupt request. A match-reset mode returns the counter to zero when it equals an externally supplied compare value, which turns the block into an up-counting modulus timer.

Software reaches the block through a byte-wide register port with five locations:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bit0 timer enable, bit1 fast flag clear, bit2 overflow interrupt enable, bit3 match reset |
| 1 | Clock | bits[2:0] prescale select, bits[5:4] clock source |
| 2 | Flag | bit0 overflow flag; writing 1 clears it |
| 3 | Count high | upper byte of the count |
| 4 | Count low | lower byte of the count |

All other register bits read as 0. A read has its side effects at the clock edge that ends the read cycle.

Top module: `prescaled_timer`

## Requirements
- R1: With the prescaler as the tick source and prescale select s (0..7), the count advances by one every 2^s enabled bus cycles. N cycles after enabling from reset, the count reads N>>s.
- R2: A newly written prescale select is not used until the prescaler counter has been at zero on a clock edge. At that edge the old select still applies and the new select governs from the next cycle.
- R3: The overflow flag (address 2, bit0) sets on the tick that moves the count from 0xFFFF to 0x0000. Writing 1 to bit0 clears the flag. Writing 0 to bit0 leaves it unchanged.
- R4: With match reset on (control bit3), a tick taken while the count equals the compare value loads zero instead of incrementing, and this reload never sets the overflow flag. With a compare value of 0xFFFF, the step from 0xFFFF to 0 therefore leaves the flag clear.
- R5: With match reset on and a compare value of 0x0000, the count stays at zero.
- R6: With fast flag clear on (control bit1), any read or write of address 3 or 4 clears the overflow flag. With fast flag clear off, such a read leaves the flag set.
- R7: When the accumulator is enabled, clock source 0 takes ticks from the prescaler, 1 counts each external tick, 2 counts every 256th external tick and 3 counts every 65536th external tick. A change of source applies from the cycle after the write.
- R8: While the accumulator is disabled, the prescaler drives the counter whatever the clock source field holds.
- R9: The interrupt request is high exactly when the overflow flag is set and the interrupt enable (control bit2) is on.
- R10: Reading address 3 captures the low byte at the same moment. The next read of address 4 returns the captured byte. A read of address 4 with no capture pending returns the live low byte.
- R11: While the timer enable is 0, both the count and the prescaler hold their values. After re-enabling, counting resumes from the held prescaler phase.
- R12: After reset, all registers read 0 and the interrupt request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| acc_on | input | 1 | Pulse accumulator enabled |
| acc_tick | input | 1 | One-cycle pulse per external accumulator clock edge |
| cmp7 | input | 16 | Channel-7 compare value used by match reset |
| irq | output | 1 | Overflow interrupt request |

## Verification
The overflow flag is the hardest state to reach from the ports, because it only sets after a full 65536-tick lap of the counter. The stimulus therefore runs two complete laps at prescale factor 1. Flag clearing by a plain read, a written 0, the interrupt enable and the fast-clear read are all tested on the first lap. The second lap is used to test the write-1 clear. Prescale realignment is reached by changing the select in the middle of a prescaler period and reading the count both before and after the next point where the prescaler is at zero.

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CW    = 16,
  parameter int PSW   = 3,
  parameter int AW    = 3,
  parameter int ACC_W = 16,
  parameter int ACC_L = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          acc_on,
  input  logic          acc_tick,
  input  logic [CW-1:0] cmp7,
  output logic          irq
);
  localparam int PST = (1 << PSW) - 1;
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_CLK = AW'(1), A_FLAG = AW'(2),
                            A_CNTH = AW'(3), A_CNTL = AW'(4);

  logic [PST-1:0]   pcnt;
  logic [PSW-1:0]   psel_q, psel_act;
  logic             en_q, ffc_q, ie_q, mr_q, ovf_q, lo_vld;
  logic [1:0]       csel_q;
  logic [CW-1:0]    cnt_q;
  logic [7:0]       lo_buf;
  logic [ACC_W-1:0] acnt;
  logic             src_tick;

  logic [PST:0] pone;
  assign pone = ({{PST{1'b0}}, 1'b1} << psel_act) - 1'b1;
  wire [PST-1:0] pmask = pone[PST-1:0];
  wire unused_ok = ^{pone[PST], bus_wdata[7:6]};

  wire pre_tick  = (pcnt & pmask) == pmask;
  wire acc_lo    = acc_tick && (&acnt[ACC_L-1:0]);
  wire acc_all   = acc_tick && (&acnt);

  always_comb begin
    case (acc_on ? csel_q : 2'd0)
      2'd0:    src_tick = pre_tick;
      2'd1:    src_tick = acc_tick;
      2'd2:    src_tick = acc_lo;
      default: src_tick = acc_all;
    endcase
  end

  wire cnt_tick = en_q && src_tick;
  wire hit      = mr_q && (cnt_q == cmp7);
  wire wrap     = cnt_tick && !hit && (&cnt_q);
  wire cnt_acc  = (bus_rd || bus_wr) && (bus_addr == A_CNTH || bus_addr == A_CNTL);
  wire flag_clr = (bus_wr && bus_addr == A_FLAG && bus_wdata[0]) || (ffc_q && cnt_acc);
  wire rd_hi    = bus_rd && bus_addr == A_CNTH;
  wire rd_lo    = bus_rd && bus_addr == A_CNTL;

  assign irq = ovf_q & ie_q;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {4'b0, mr_q, ie_q, ffc_q, en_q};
      A_CLK:   bus_rdata = {2'b0, csel_q, 1'b0, psel_q};
      A_FLAG:  bus_rdata = {7'b0, ovf_q};
      A_CNTH:  bus_rdata = cnt_q[CW-1:CW-8];
      A_CNTL:  bus_rdata = lo_vld ? lo_buf : cnt_q[7:0];
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, ffc_q, ie_q, mr_q} <= '0;
      csel_q   <= '0;
      psel_q   <= '0;
      psel_act <= '0;
      pcnt     <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
      lo_buf   <= '0;
      lo_vld   <= 1'b0;
      acnt     <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) {mr_q, ie_q, ffc_q, en_q} <= bus_wdata[3:0];
      if (bus_wr && bus_addr == A_CLK) begin
        csel_q <= bus_wdata[5:4];
        psel_q <= bus_wdata[PSW-1:0];
      end
      if (en_q) pcnt <= pcnt + 1'b1;
      if (pcnt == '0) psel_act <= psel_q;
      if (acc_on && acc_tick) acnt <= acnt + 1'b1;
      if (cnt_tick) cnt_q <= hit ? '0 : cnt_q + 1'b1;
      if (wrap) ovf_q <= 1'b1;
      else if (flag_clr) ovf_q <= 1'b0;
      if (rd_hi) begin
        lo_buf <= cnt_q[7:0];
        lo_vld <= 1'b1;
      end else if (rd_lo) lo_vld <= 1'b0;
    end
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
  assert_realign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (psel_act == $past(psel_act) || $past(pcnt) == '0));
  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && (&cnt_q) && !hit) |=> ovf_q);
  assert_match_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && hit) |=> (cnt_q == '0));
  assert_match_noovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && hit && !ovf_q) |=> !ovf_q);
  assert_irq_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_q);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (cnt_q == $past(cnt_q) && pcnt == $past(pcnt)));
endmodule

// File: tb/tb_prescaled_timer.sv
module tb_prescaled_timer;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, acc_on = 0, acc_tick = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [15:0] cmp7 = 16'h1234;
  logic irq;
  int checks = 0, fails = 0;

  prescaled_timer dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .acc_on(acc_on), .acc_tick(acc_tick), .cmp7(cmp7), .irq(irq));

  always #5 clk = ~clk;

  function automatic logic [15:0] exp_pre(input int n, input int s);
    return 16'(n >> s);
  endfunction

  function automatic logic [15:0] exp_realign(input int n);
    return 16'(129 + (n - 128) / 4);
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(3, h);
    rd(4, l);
    v = {h, l};
  endtask

  task automatic pulses(input int n);
    repeat (n) begin
      @(negedge clk) acc_tick = 1;
      @(negedge clk) acc_tick = 0;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    void'($urandom(32'd2024));
    do_reset();

    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b);
      chk("R12 reg", {8'h0, b}, 16'h0);
    end
    chk("R12 irq", {15'h0, irq}, 16'h0);

    for (int i = 0; i < 8; i++) begin
      int s, m;
      s = (i < 2) ? i * 7 : int'($urandom % 8);
      m = int'($urandom % 1024);
      do_reset();
      wr(1, 8'(s));
      wr(0, 8'h01);
      repeat (m) @(posedge clk);
      rd16(v);
      chk($sformatf("R1 s=%0d n=%0d", s, m), v, exp_pre(m, s));
    end

    do_reset();
    wr(0, 8'h01);
    repeat (10) @(posedge clk);
    wr(1, 8'h02);
    repeat (89) @(posedge clk);
    rd16(v);
    chk("R2 before realign", v, 16'd100);
    repeat (98) @(posedge clk);
    rd16(v);
    chk("R2 after realign", v, exp_realign(200));

    do_reset();
    wr(1, 8'h02);
    wr(0, 8'h01);
    repeat (5) @(posedge clk);
    wr(0, 8'h00);
    repeat (37) @(posedge clk);
    rd16(v);
    chk("R11 held count", v, 16'd1);
    wr(0, 8'h01);
    repeat (2) @(posedge clk);
    rd16(v);
    chk("R11 prescaler phase kept", v, 16'd2);

    do_reset();
    cmp7 = 16'd5;
    wr(0, 8'h09);
    repeat (100) @(posedge clk);
    rd16(v);
    chk("R4 modulus count", v, 16'd4);
    rd(2, b);
    chk("R4 no flag", {8'h0, b}, 16'h0);

    do_reset();
    cmp7 = 16'd0;
    wr(0, 8'h09);
    repeat (50) @(posedge clk);
    rd16(v);
    chk("R5 stuck at zero", v, 16'd0);
    cmp7 = 16'h1234;

    do_reset();
    wr(0, 8'h01);
    repeat (300) @(posedge clk);
    rd(3, b);
    chk("R10 high byte", {8'h0, b}, 16'h01);
    rd(4, b);
    chk("R10 captured low", {8'h0, b}, 16'h2C);
    rd(4, b);
    chk("R10 live low", {8'h0, b}, 16'h2E);

    do_reset();
    acc_on = 1;
    wr(0, 8'h01);
    repeat (20) @(posedge clk);
    wr(1, 8'h10);
    repeat (15) @(posedge clk);
    rd16(v);
    chk("R7 switch immediate", v, 16'd21);
    pulses(300);
    rd16(v);
    chk("R7 source 1", v, 16'd321);

    do_reset();
    wr(1, 8'h20);
    wr(0, 8'h01);
    pulses(600);
    rd16(v);
    chk("R7 source 2", v, 16'd2);

    do_reset();
    wr(1, 8'h30);
    wr(0, 8'h01);
    pulses(600);
    rd16(v);
    chk("R7 source 3", v, 16'd0);

    do_reset();
    acc_on = 0;
    wr(1, 8'h10);
    wr(0, 8'h01);
    pulses(20);
    rd16(v);
    chk("R8 prescaler forced", v, 16'd40);

    do_reset();
    wr(0, 8'h01);
    repeat (65540) @(posedge clk);
    rd(2, b);
    chk("R3 flag set", {8'h0, b}, 16'h1);
    chk("R9 irq masked", {15'h0, irq}, 16'h0);
    wr(2, 8'h00);
    rd(2, b);
    chk("R3 write 0 no effect", {8'h0, b}, 16'h1);
    rd16(v);
    rd(2, b);
    chk("R6 plain read keeps flag", {8'h0, b}, 16'h1);
    wr(0, 8'h05);
    chk("R9 irq raised", {15'h0, irq}, 16'h1);
    wr(0, 8'h07);
    rd(3, b);
    rd(2, b);
    chk("R6 fast clear by read", {8'h0, b}, 16'h0);
    chk("R9 irq dropped", {15'h0, irq}, 16'h0);
    wr(0, 8'h05);
    repeat (65600) @(posedge clk);
    rd(2, b);
    chk("R3 flag set lap 2", {8'h0, b}, 16'h1);
    chk("R9 irq lap 2", {15'h0, irq}, 16'h1);
    wr(2, 8'h01);
    rd(2, b);
    chk("R3 write 1 clears", {8'h0, b}, 16'h0);
    chk("R9 irq after clear", {15'h0, irq}, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule